// File: doc/BRIEF.md
# Multi-Cycle Accumulator CPU Sequencer

This block is a compact 8-bit accumulator processor whose control is a hand-built finite state machine. Code and data live in one 16-byte memory that is reached only through a memory address register. Every instruction starts with the same two steps. The address step copies the program counter into the address register. The decode step captures the addressed byte in the instruction register and picks the next state from its opcode. The execute steps that follow depend on the instruction. When they finish, the machine returns to the address step. A halt instruction parks the machine for good.

The program counter is the only register clocked on the falling clock edge. Because of this, its increment lands halfway through the decode cycle instead of costing a cycle of its own. The memory is filled through a valid/ready preload stream. The stream is ready only while reset is held, and a beat is taken on a rising edge where both valid and ready are high. Outside reset the stream applies back-pressure for good and any offered beat is dropped. The current state and a halted flag are brought out, so a testbench can compare cycle counts against a preloaded program.

Top module: `cpu_seq_top`

## Requirements
- R1: A synchronous active-high reset, sampled on the rising edge (and for the program counter on the falling edge), clears the program counter, accumulator, carry, zero, output register, address register and instruction register, and sets the state to address step (code 0). Memory contents are kept.
- R2: `pl_ready_o` equals `rst`. A memory byte is written from `pl_data_i` at `pl_addr_i` only on a rising edge with `pl_valid_i` and `pl_ready_o` both high. Beats offered outside reset change nothing.
- R3: State encoding on `state_o`: 0 address step, 1 decode, 2 operand address, 3 load, 4 add, 5 subtract, 6 store, 7 immediate, 8 jump, 9 output, 15 halt. State 0 copies the program counter into the address register and is always followed by state 1.
- R4: In state 1 the instruction register takes the addressed byte on the next rising edge. The program counter increments by one (modulo 16) on the falling edge inside that same decode cycle.
- R5: An instruction byte holds the opcode in bits 7:4 and the address or immediate in bits 3:0. Cycles per instruction, counting the address and decode steps: opcodes 1, 2, 3 and 4 take 4; opcodes 5, 6 and 14 take 3; opcode 0 and every undefined opcode (7 to 13) act as a no-op and take 2.
- R6: Opcodes 1 (load), 2 (add), 3 (subtract) and 4 (store) first move bits 3:0 into the address register (state 2). The second execute state then reads memory into the accumulator or the ALU, or writes the accumulator to memory. Code and data share the same memory.
- R7: Opcode 5 loads the accumulator with bits 3:0, zero-extended.
- R8: Add sets carry to the carry-out of the 8-bit sum. Subtract sets carry to 1 when no borrow occurs (accumulator ≥ operand). Both set zero when the 8-bit result is 0. No other instruction changes either flag.
- R9: Opcode 6 loads the program counter with bits 3:0 on the falling edge of its execute cycle.
- R10: Opcode 14 copies the accumulator into the output register.
- R11: Opcode 15 enters state 15. That state is absorbing, `halted_o` is high in it, and no register changes after it is entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the program counter uses its falling edge |
| rst | input | 1 | Synchronous active-high reset |
| pl_valid_i | input | 1 | Preload beat offered |
| pl_ready_o | output | 1 | Preload beat accepted (high only in reset) |
| pl_addr_i | input | 4 | Preload byte address |
| pl_data_i | input | 8 | Preload byte |
| state_o | output | 4 | Current sequencer state code |
| halted_o | output | 1 | High in the halt state |
| pc_o | output | 4 | Program counter |
| acc_o | output | 8 | Accumulator |
| out_o | output | 8 | Output register |
| carry_o | output | 1 | Carry flag |
| zero_o | output | 1 | Zero flag |

## Verification
`state_o` is visible every cycle, so a wrong next-state choice shows at the ports one rising edge after the faulty decode. The count of edges to `halted_o` then moves by whole instruction lengths. A program counter that steps at the wrong edge or by the wrong amount can be seen half a cycle into decode. It also makes the program fetch wrong bytes, which shows up in the output register and flags at halt. Accumulator, flag and store faults surface through the output register, which stays frozen once halted, so the final value can be read at leisure.

// File: rtl/cpu_seq_pkg.sv
package cpu_seq_pkg;

  localparam int OP_W = 4;

  typedef enum logic [3:0] {
    S_FETCH  = 4'd0,
    S_DECODE = 4'd1,
    S_OPADDR = 4'd2,
    S_LOAD   = 4'd3,
    S_ADD    = 4'd4,
    S_SUB    = 4'd5,
    S_STORE  = 4'd6,
    S_IMM    = 4'd7,
    S_JUMP   = 4'd8,
    S_OUT    = 4'd9,
    S_HALT   = 4'd15
  } seq_state_e;

  localparam logic [OP_W-1:0] OP_LOAD  = 4'd1;
  localparam logic [OP_W-1:0] OP_ADD   = 4'd2;
  localparam logic [OP_W-1:0] OP_SUB   = 4'd3;
  localparam logic [OP_W-1:0] OP_STORE = 4'd4;
  localparam logic [OP_W-1:0] OP_IMM   = 4'd5;
  localparam logic [OP_W-1:0] OP_JUMP  = 4'd6;
  localparam logic [OP_W-1:0] OP_OUT   = 4'd14;
  localparam logic [OP_W-1:0] OP_HALT  = 4'd15;

  typedef struct packed {
    logic mar_from_pc;
    logic mar_from_ir;
    logic ir_load;
    logic pc_step;
    logic pc_jump;
    logic acc_from_mem;
    logic acc_from_alu;
    logic acc_from_imm;
    logic alu_sub;
    logic mem_write;
    logic out_load;
  } seq_ctl_t;

endpackage

// File: rtl/cpu_seq_alu.sv
module cpu_seq_alu #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] res_o,
  output logic              carry_o,
  output logic              zero_o
);

  localparam int WIDE_W = DATA_W + 1;

  logic [WIDE_W-1:0] wide;

  always_comb begin
    if (sub_i) wide = {1'b0, a_i} - {1'b0, b_i};
    else       wide = {1'b0, a_i} + {1'b0, b_i};
  end

  assign res_o   = wide[DATA_W-1:0];
  // subtract reports "no borrow" as carry set
  assign carry_o = sub_i ? ~wide[DATA_W] : wide[DATA_W];
  assign zero_o  = (wide[DATA_W-1:0] == '0);

endmodule

// File: rtl/cpu_seq_mem.sv
module cpu_seq_mem #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pl_valid_i,
  output logic              pl_ready_o,
  input  logic [ADDR_W-1:0] pl_addr_i,
  input  logic [DATA_W-1:0] pl_data_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];
  logic              pl_take;

  assign pl_ready_o = rst;
  assign pl_take    = pl_valid_i & pl_ready_o;

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (pl_take && (pl_addr_i == ADDR_W'(i))) cells[i] <= pl_data_i;
      else if (wr_en_i && (addr_i == ADDR_W'(i))) cells[i] <= wdata_i;
    end
  end

  assign rdata_o = cells[addr_i];

  AST_NO_RUN_WRITE_IN_RESET: assert property (@(posedge clk)
    rst |-> !wr_en_i); // R2

endmodule

// File: rtl/cpu_seq_ctrl.sv
module cpu_seq_ctrl
  import cpu_seq_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] mem_op_i,
  input  logic [OP_W-1:0] ir_op_i,
  output seq_state_e      state_o,
  output seq_ctl_t        ctl_o
);

  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_FETCH:  state_d = S_DECODE;
      S_DECODE: begin
        case (mem_op_i)
          OP_LOAD, OP_ADD, OP_SUB, OP_STORE: state_d = S_OPADDR;
          OP_IMM:  state_d = S_IMM;
          OP_JUMP: state_d = S_JUMP;
          OP_OUT:  state_d = S_OUT;
          OP_HALT: state_d = S_HALT;
          default: state_d = S_FETCH;
        endcase
      end
      S_OPADDR: begin
        case (ir_op_i)
          OP_LOAD: state_d = S_LOAD;
          OP_ADD:  state_d = S_ADD;
          OP_SUB:  state_d = S_SUB;
          default: state_d = S_STORE;
        endcase
      end
      S_HALT:  state_d = S_HALT;
      default: state_d = S_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= S_FETCH;
    else     state_q <= state_d;
  end

  always_comb begin
    ctl_o = '0;
    unique case (state_q)
      S_FETCH:  ctl_o.mar_from_pc = 1'b1;
      S_DECODE: begin
        ctl_o.ir_load = 1'b1;
        ctl_o.pc_step = 1'b1;
      end
      S_OPADDR: ctl_o.mar_from_ir  = 1'b1;
      S_LOAD:   ctl_o.acc_from_mem = 1'b1;
      S_ADD:    ctl_o.acc_from_alu = 1'b1;
      S_SUB: begin
        ctl_o.acc_from_alu = 1'b1;
        ctl_o.alu_sub      = 1'b1;
      end
      S_STORE:  ctl_o.mem_write    = 1'b1;
      S_IMM:    ctl_o.acc_from_imm = 1'b1;
      S_JUMP:   ctl_o.pc_jump      = 1'b1;
      S_OUT:    ctl_o.out_load     = 1'b1;
      default:  ctl_o = '0;
    endcase
  end

  assign state_o = state_q;

  AST_FETCH_THEN_DECODE: assert property (@(posedge clk) disable iff (rst)
    state_q == S_FETCH |=> state_q == S_DECODE); // R3

  AST_HALT_ABSORBS: assert property (@(posedge clk) disable iff (rst)
    state_q == S_HALT |=> state_q == S_HALT); // R11

  AST_EXEC_RETURNS: assert property (@(posedge clk) disable iff (rst)
    (state_q inside {S_LOAD, S_ADD, S_SUB, S_STORE, S_IMM, S_JUMP, S_OUT})
    |=> state_q == S_FETCH); // R5

  AST_OPADDR_NEXT: assert property (@(posedge clk) disable iff (rst)
    state_q == S_OPADDR |=> (state_q inside {S_LOAD, S_ADD, S_SUB, S_STORE})); // R6

  AST_ACC_SRC_ONE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctl_o.acc_from_mem, ctl_o.acc_from_alu, ctl_o.acc_from_imm})); // R6

endmodule

// File: rtl/cpu_seq_regs.sv
module cpu_seq_regs
  import cpu_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  seq_ctl_t          ctl_i,
  input  logic              halted_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic [DATA_W-1:0] alu_res_i,
  input  logic              alu_carry_i,
  input  logic              alu_zero_i,
  output logic [ADDR_W-1:0] mar_o,
  output logic [DATA_W-1:0] ir_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] acc_o,
  output logic [DATA_W-1:0] out_o,
  output logic              carry_o,
  output logic              zero_o
);

  localparam int EXT_W = DATA_W - ADDR_W;

  logic [ADDR_W-1:0] mar_q, pc_q;
  logic [DATA_W-1:0] ir_q, acc_q, out_q;
  logic              carry_q, zero_q;
  logic [ADDR_W-1:0] field;

  assign field = ir_q[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      mar_q   <= '0;
      ir_q    <= '0;
      acc_q   <= '0;
      out_q   <= '0;
      carry_q <= 1'b0;
      zero_q  <= 1'b0;
    end else begin
      if (ctl_i.mar_from_pc)      mar_q <= pc_q;
      else if (ctl_i.mar_from_ir) mar_q <= field;
      if (ctl_i.ir_load) ir_q <= mem_rdata_i;
      if (ctl_i.acc_from_mem) begin
        acc_q <= mem_rdata_i;
      end else if (ctl_i.acc_from_alu) begin
        acc_q   <= alu_res_i;
        carry_q <= alu_carry_i;
        zero_q  <= alu_zero_i;
      end else if (ctl_i.acc_from_imm) begin
        acc_q <= {{EXT_W{1'b0}}, field};
      end
      if (ctl_i.out_load) out_q <= acc_q;
    end
  end

  // program counter advances half a cycle into decode
  always_ff @(negedge clk) begin
    if (rst)                pc_q <= '0;
    else if (ctl_i.pc_step) pc_q <= pc_q + 1'b1;
    else if (ctl_i.pc_jump) pc_q <= field;
  end

  assign mar_o   = mar_q;
  assign ir_o    = ir_q;
  assign pc_o    = pc_q;
  assign acc_o   = acc_q;
  assign out_o   = out_q;
  assign carry_o = carry_q;
  assign zero_o  = zero_q;

  AST_PC_STEP_IN_DECODE: assert property (@(posedge clk) disable iff (rst)
    ctl_i.pc_step |-> pc_q == ADDR_W'($past(pc_q) + 1'b1)); // R4

  AST_PC_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
    ctl_i.pc_jump |-> pc_q == field); // R9

  AST_ZERO_MATCHES_ACC: assert property (@(posedge clk) disable iff (rst)
    ctl_i.acc_from_alu |=> zero_q == (acc_q == '0)); // R8

  AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (rst)
    halted_i |=> ($stable(pc_q) && $stable(acc_q) && $stable(out_q)
                  && $stable(ir_q) && $stable(mar_q))); // R11

endmodule

// File: rtl/cpu_seq_top.sv
module cpu_seq_top
  import cpu_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     pl_valid_i,
  output logic                     pl_ready_o,
  input  logic [DATA_W-OP_W-1:0]   pl_addr_i,
  input  logic [DATA_W-1:0]        pl_data_i,
  output logic [3:0]               state_o,
  output logic                     halted_o,
  output logic [DATA_W-OP_W-1:0]   pc_o,
  output logic [DATA_W-1:0]        acc_o,
  output logic [DATA_W-1:0]        out_o,
  output logic                     carry_o,
  output logic                     zero_o
);

  localparam int ADDR_W = DATA_W - OP_W;

  seq_state_e        state;
  seq_ctl_t          ctl;
  logic [ADDR_W-1:0] mar;
  logic [DATA_W-1:0] ir, acc, mem_rdata, alu_res;
  logic              alu_carry, alu_zero, halted;

  assign halted = (state == S_HALT);

  cpu_seq_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .mem_op_i (mem_rdata[DATA_W-1 -: OP_W]),
    .ir_op_i  (ir[DATA_W-1 -: OP_W]),
    .state_o  (state),
    .ctl_o    (ctl)
  );

  cpu_seq_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .clk        (clk),
    .rst        (rst),
    .pl_valid_i (pl_valid_i),
    .pl_ready_o (pl_ready_o),
    .pl_addr_i  (pl_addr_i),
    .pl_data_i  (pl_data_i),
    .addr_i     (mar),
    .rdata_o    (mem_rdata),
    .wr_en_i    (ctl.mem_write),
    .wdata_i    (acc)
  );

  cpu_seq_alu #(.DATA_W(DATA_W)) u_alu (
    .a_i     (acc),
    .b_i     (mem_rdata),
    .sub_i   (ctl.alu_sub),
    .res_o   (alu_res),
    .carry_o (alu_carry),
    .zero_o  (alu_zero)
  );

  cpu_seq_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .ctl_i       (ctl),
    .halted_i    (halted),
    .mem_rdata_i (mem_rdata),
    .alu_res_i   (alu_res),
    .alu_carry_i (alu_carry),
    .alu_zero_i  (alu_zero),
    .mar_o       (mar),
    .ir_o        (ir),
    .pc_o        (pc_o),
    .acc_o       (acc),
    .out_o       (out_o),
    .carry_o     (carry_o),
    .zero_o      (zero_o)
  );

  assign state_o  = state;
  assign halted_o = halted;
  assign acc_o    = acc;

endmodule

// File: tb/cpu_seq_top_tb.sv
module cpu_seq_top_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pl_valid = 1'b0;
  logic       pl_ready;
  logic [3:0] pl_addr = '0;
  logic [7:0] pl_data = '0;
  logic [3:0] state;
  logic       halted;
  logic [3:0] pc;
  logic [7:0] acc, outr;
  logic       carry, zero;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [7:0] img [16];

  always #4 clk = ~clk;

  cpu_seq_top u_dut (
    .clk(clk), .rst(rst), .pl_valid_i(pl_valid), .pl_ready_o(pl_ready),
    .pl_addr_i(pl_addr), .pl_data_i(pl_data), .state_o(state),
    .halted_o(halted), .pc_o(pc), .acc_o(acc), .out_o(outr),
    .carry_o(carry), .zero_o(zero)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_img();
    for (int i = 0; i < 16; i++) img[i] = 8'h00;
  endtask

  // step to just after the next rising edge
  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic boot();
    rst = 1'b1;
    tick();
    for (int i = 0; i < 16; i++) begin
      pl_valid = 1'b1;
      pl_addr  = 4'(i);
      pl_data  = img[i];
      tick();
    end
    pl_valid = 1'b0;
    tick();
    rst = 1'b0;
  endtask

  task automatic run_to_halt(output int n);
    n = 0;
    while (!halted && n < 300) begin
      tick();
      n++;
    end
  endtask

  task automatic t_reset();
    clear_img();
    img[0] = 8'h55;
    boot();
    rst = 1'b1;
    tick();
    chk("R1 state", state, 0);
    chk("R1 pc", pc, 0);
    chk("R1 acc", acc, 0);
    chk("R1 out", outr, 0);
    chk("R1 flags", {carry, zero}, 0);
    chk("R1 halted", halted, 0);
    chk("R2 ready in reset", pl_ready, 1);
    rst = 1'b0;
    tick();
    chk("R2 ready after reset", pl_ready, 0);
  endtask

  task automatic t_trace();
    clear_img();
    img[0] = 8'h55; img[1] = 8'hF0;
    boot();
    tick();
    chk("R3 decode follows fetch", state, 1);
    chk("R4 pc before falling edge", pc, 0);
    #4;
    chk("R4 pc after falling edge", pc, 1);
    chk("R4 still decoding", state, 1);
    tick();
    chk("R3 immediate state code", state, 7);
    tick();
    chk("R7 immediate zero-extended", acc, 5);
    chk("R3 back to fetch", state, 0);
  endtask

  task automatic t_add();
    int n;
    clear_img();
    img[0] = 8'h55; img[1] = 8'h2E; img[2] = 8'hE0; img[3] = 8'hF0;
    img[14] = 8'h07;
    boot();
    pl_valid = 1'b1; pl_addr = 4'd14; pl_data = 8'h50;
    run_to_halt(n);
    pl_valid = 1'b0;
    chk("R5 cycles imm/add/out/halt", n, 12);
    chk("R10 out after add", outr, 12);
    chk("R2 run-time beat ignored", acc, 12);
    chk("R8 add flags", {carry, zero}, 0);
  endtask

  task automatic t_sub();
    int n;
    clear_img();
    img[0] = 8'h1D; img[1] = 8'h3C; img[2] = 8'h3B; img[3] = 8'hE0; img[4] = 8'hF0;
    img[11] = 8'h06; img[12] = 8'h05; img[13] = 8'h05;
    boot();
    for (int i = 0; i < 8; i++) tick();
    chk("R6 load then subtract", acc, 0);
    chk("R8 sub equal carry", carry, 1);
    chk("R8 sub equal zero", zero, 1);
    run_to_halt(n);
    chk("R5 remaining cycles", n, 9);
    chk("R8 sub borrow result", outr, 250);
    chk("R8 sub borrow flags", {carry, zero}, 0);
  endtask

  task automatic t_store();
    int n;
    clear_img();
    img[0] = 8'h5F; img[1] = 8'h2A; img[2] = 8'h49; img[3] = 8'h53;
    img[4] = 8'h19; img[5] = 8'hE0; img[6] = 8'hF0; img[10] = 8'hF2;
    boot();
    run_to_halt(n);
    chk("R5 cycles store program", n, 23);
    chk("R6 store then reload", outr, 1);
    chk("R8 add carry-out kept past load", carry, 1);
    chk("R8 zero after add", zero, 0);
  endtask

  task automatic t_jump_halt();
    int n;
    logic [7:0] acc_h, out_h;
    logic [3:0] pc_h;
    clear_img();
    img[0] = 8'h51; img[1] = 8'h64; img[2] = 8'hE0; img[3] = 8'hF0;
    img[4] = 8'h00; img[5] = 8'h7A; img[6] = 8'h59; img[7] = 8'hE0; img[8] = 8'hF0;
    boot();
    run_to_halt(n);
    chk("R5 cycles jump/no-op program", n, 18);
    chk("R9 jump skipped output", outr, 9);
    chk("R9 pc after halt", pc, 9);
    chk("R11 halted flag", halted, 1);
    acc_h = acc; out_h = outr; pc_h = pc;
    for (int i = 0; i < 20; i++) tick();
    chk("R11 halt state held", state, 15);
    chk("R11 pc frozen", pc, pc_h);
    chk("R11 acc frozen", acc, acc_h);
    chk("R11 out frozen", outr, out_h);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_trace();
    t_add();
    t_sub();
    t_store();
    t_jump_halt();
    finish_run();
  end

endmodule